// File: doc/BRIEF.md
# Two-Stage RTC Tick Prescaler

This block turns a slow real-time-clock input into a periodic time-base tick. A fixed divide-by-64 counter runs first. A programmable down-counter follows it and is loaded from a 20-bit reload value, so the tick period is 64 × (reload + 1) RTC cycles. A reload of zero does not stall the second stage. It is treated as divide-by-2, which gives a period of 128 RTC cycles.

Software programs the block from the system clock domain through a small write port. The reload value is split over two registers. The upper 4 bits go into a shadow register. Writing the lower 16 bits commits all 20 bits at once. The committed value crosses into the RTC domain and is loaded only when the running period ends. Each tick is carried back into the system clock domain, where it sets a sticky flag and, when enabled, an interrupt. The crossing is built on the assumption that the RTC clock runs at least four times slower than the system clock.

Top module: `rtc_tick_prescaler`

## Requirements
- R1: With a committed non-zero reload N, consecutive rising edges of `tick_o` are exactly 64 × (N + 1) RTC cycles apart.
- R2: With a committed reload of 0, consecutive ticks are exactly 128 RTC cycles apart.
- R3: The reload value is {high[3:0], low[15:0]}. Address 2 carries bits 19:16 in data bits 3:0. Address 3 carries bits 15:0 in data bits 15:0.
- R4: A write to address 2 alone leaves the committed reload unchanged. A write to address 3 commits the staged high part together with the written low part as one value.
- R5: A newly committed reload first applies to the period that begins after the next tick. The period in progress always runs to its full length.
- R6: After reset, the enable bit, the interrupt-enable bit, the flag, `tick_o` and `irq_o` are all 0, and the reload is 511. The first tick after enabling arrives 32768 RTC cycles later, plus a few cycles of synchronizer latency.
- R7: Control register (address 0) bit 0 is the enable. While it is 0, no tick is produced and both divider stages are cleared. After it is set, the first period is a full period.
- R8: Each tick sets `flag_o` exactly once, within 6 system cycles of the rising edge of `tick_o`.
- R9: Writing address 1 with data bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged. If a set and a clear occur in the same cycle, the set wins.
- R10: `irq_o` is 1 only when the flag is set and control bit 1 (interrupt enable) is 1.
- R11: `tick_o` is high for exactly one RTC cycle per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | System clock; register writes, flag and interrupt |
| rtc_clk_i | input | 1 | Slow RTC input clock, at least 4x slower than sys_clk_i |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Register write strobe (system domain) |
| wr_addr_i | input | 2 | 0 control, 1 flag clear, 2 reload high, 3 reload low |
| wr_data_i | input | 16 | Write data |
| tick_o | output | 1 | One-RTC-cycle time-base tick (RTC domain) |
| flag_o | output | 1 | Sticky tick flag (system domain) |
| irq_o | output | 1 | Flag gated by the interrupt enable |

## Verification
Two situations are hard to reach from the ports. The first is the reset-default period, which lasts 32768 RTC cycles. The bench enables the block once straight out of reset and measures the delay to the first tick. After that it disables the block and commits short reload values, so the cycle-exact comparison runs over many periods. The second is proving that the high reload bits are decoded. The bench commits 65536 right after a tick, lets the 384-cycle period in progress finish, and then confirms that no tick appears for a thousand cycles, well past the point where a 128-cycle period would have ended.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  localparam int unsigned PRE_W_DEF   = 6;
  localparam int unsigned HI_W_DEF    = 4;
  localparam int unsigned LO_W_DEF    = 16;
  localparam int unsigned RLD_RST_DEF = 511;
  localparam int unsigned SYNC_N_DEF  = 2;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CLR    = 2'd1,
    REG_RLD_HI = 2'd2,
    REG_RLD_LO = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rtc_tick_regs.sv
module rtc_tick_regs
  import rtc_tick_pkg::*;
#(
  parameter int unsigned HI_W    = HI_W_DEF,
  parameter int unsigned LO_W    = LO_W_DEF,
  parameter int unsigned RLD_RST = RLD_RST_DEF,
  localparam int unsigned RLD_W  = HI_W + LO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [LO_W-1:0]  wr_data_i,
  output logic             en_o,
  output logic             irq_en_o,
  output logic             clr_o,
  output logic [RLD_W-1:0] reload_o,
  output logic             commit_tgl_o
);
  localparam logic [RLD_W-1:0] RST_V = RLD_W'(RLD_RST);

  logic [HI_W-1:0] hi_shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o         <= 1'b0;
      irq_en_o     <= 1'b0;
      hi_shadow_q  <= RST_V[RLD_W-1:LO_W];
      reload_o     <= RST_V;
      commit_tgl_o <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        REG_CTRL: begin
          en_o     <= wr_data_i[0];
          irq_en_o <= wr_data_i[1];
        end
        REG_RLD_HI: hi_shadow_q <= wr_data_i[HI_W-1:0];
        REG_RLD_LO: begin
          // low write commits the full value in one step
          reload_o     <= {hi_shadow_q, wr_data_i};
          commit_tgl_o <= ~commit_tgl_o;
        end
        default: ;
      endcase
    end
  end

  assign clr_o = wr_en_i && (wr_addr_i == REG_CLR) && wr_data_i[0];
endmodule

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider
  import rtc_tick_pkg::*;
#(
  parameter int unsigned PRE_W   = PRE_W_DEF,
  parameter int unsigned RLD_W   = HI_W_DEF + LO_W_DEF,
  parameter int unsigned RLD_RST = RLD_RST_DEF,
  parameter int unsigned SYNC_N  = SYNC_N_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             commit_tgl_i,
  output logic             en_sync_o,
  output logic             tick_o
);
  localparam logic [RLD_W-1:0] RST_V = RLD_W'(RLD_RST);

  logic [SYNC_N-1:0] en_sh_q;
  logic [SYNC_N:0]   tgl_sh_q;
  logic [RLD_W-1:0]  pend_q;
  logic [RLD_W-1:0]  cnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic [RLD_W-1:0]  load_val;
  logic              pre_wrap;
  logic              commit_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_sh_q  <= '0;
      tgl_sh_q <= '0;
    end else begin
      en_sh_q  <= {en_sh_q[SYNC_N-2:0], en_i};
      tgl_sh_q <= {tgl_sh_q[SYNC_N-1:0], commit_tgl_i};
    end
  end

  assign en_sync_o  = en_sh_q[SYNC_N-1];
  assign commit_evt = tgl_sh_q[SYNC_N] ^ tgl_sh_q[SYNC_N-1];

  // bus held stable in source domain across the toggle crossing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= RST_V;
    else if (commit_evt) pend_q <= reload_i;
  end

  // zero reload behaves as one: second stage divides by two
  assign load_val = (pend_q == '0) ? RLD_W'(1) : pend_q;
  assign pre_wrap = &pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      cnt_q  <= (RST_V == '0) ? RLD_W'(1) : RST_V;
      tick_o <= 1'b0;
    end else if (!en_sync_o) begin
      pre_q  <= '0;
      cnt_q  <= load_val;
      tick_o <= 1'b0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      tick_o <= pre_wrap && (cnt_q == '0);
      if (pre_wrap) cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_tick_flag.sv
module rtc_tick_flag
  import rtc_tick_pkg::*;
#(
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic set_o,
  output logic flag_o,
  output logic irq_o
);
  logic [SYNC_N:0] tk_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tk_sh_q <= '0;
      flag_o  <= 1'b0;
    end else begin
      tk_sh_q <= {tk_sh_q[SYNC_N-1:0], tick_i};
      flag_o  <= set_o | (flag_o & ~clr_i);
    end
  end

  // tick lasts >= 4 sys cycles, so one rising edge per tick
  assign set_o = tk_sh_q[SYNC_N-1] & ~tk_sh_q[SYNC_N];
  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler
  import rtc_tick_pkg::*;
#(
  parameter int unsigned PRE_W   = PRE_W_DEF,
  parameter int unsigned HI_W    = HI_W_DEF,
  parameter int unsigned LO_W    = LO_W_DEF,
  parameter int unsigned RLD_RST = RLD_RST_DEF,
  parameter int unsigned SYNC_N  = SYNC_N_DEF
) (
  input  logic            sys_clk_i,
  input  logic            rtc_clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [LO_W-1:0] wr_data_i,
  output logic            tick_o,
  output logic            flag_o,
  output logic            irq_o
);
  localparam int unsigned RLD_W = HI_W + LO_W;

  logic             en_q;
  logic             irq_en;
  logic             clr;
  logic [RLD_W-1:0] reload_q;
  logic             commit_tgl;
  logic             en_rtc;
  logic             flag_set;

  rtc_tick_regs #(
    .HI_W(HI_W), .LO_W(LO_W), .RLD_RST(RLD_RST)
  ) u_regs (
    .clk_i(sys_clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .en_o(en_q), .irq_en_o(irq_en), .clr_o(clr),
    .reload_o(reload_q), .commit_tgl_o(commit_tgl)
  );

  rtc_tick_divider #(
    .PRE_W(PRE_W), .RLD_W(RLD_W), .RLD_RST(RLD_RST), .SYNC_N(SYNC_N)
  ) u_div (
    .clk_i(rtc_clk_i), .rst_ni(rst_ni),
    .en_i(en_q), .reload_i(reload_q), .commit_tgl_i(commit_tgl),
    .en_sync_o(en_rtc), .tick_o(tick_o)
  );

  rtc_tick_flag #(
    .SYNC_N(SYNC_N)
  ) u_flag (
    .clk_i(sys_clk_i), .rst_ni(rst_ni),
    .tick_i(tick_o), .clr_i(clr), .irq_en_i(irq_en),
    .set_o(flag_set), .flag_o(flag_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/rtc_tick_prescaler_chk.sv
module rtc_tick_prescaler_chk #(
  parameter int unsigned RLD_W = 20
) (
  input logic             sys_clk_i,
  input logic             rtc_clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic             tick_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             irq_en_i,
  input logic             en_rtc_i,
  input logic             clr_i,
  input logic             set_i,
  input logic [RLD_W-1:0] reload_i
);
  // R11
  tick_one_cycle_chk: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R7
  no_tick_when_off_chk: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    !en_rtc_i |=> !tick_o);

  // R4
  hi_write_no_commit_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd2) |=> $stable(reload_i));

  // R8
  flag_follows_set_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  // R9
  flag_sticky_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  // R9
  flag_clear_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);

  // R10
  irq_needs_flag_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);

  // R10
  irq_masked_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
endmodule

bind rtc_tick_prescaler rtc_tick_prescaler_chk #(.RLD_W(RLD_W)) u_chk (
  .sys_clk_i(sys_clk_i), .rtc_clk_i(rtc_clk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .tick_o(tick_o), .flag_o(flag_o), .irq_o(irq_o),
  .irq_en_i(irq_en), .en_rtc_i(en_rtc), .clr_i(clr), .set_i(flag_set),
  .reload_i(reload_q)
);

// File: tb/rtc_tick_prescaler_bench.sv
`timescale 1ns/1ps
module rtc_tick_prescaler_bench;
  logic        sys_clk = 1'b0;
  logic        rtc_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        wr_en   = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick, flag, irq;

  int checks = 0, fails = 0;
  int rtc_cyc = 0, tick_cnt = 0, last_tick_cyc = 0;
  int remaining = 0, model_pend = 511;
  bit lock_req = 0, locked = 0, tick_prev = 0, irq_exp = 0, done = 0;

  always #10 sys_clk = ~sys_clk;
  initial begin
    #5;
    forever #40 rtc_clk = ~rtc_clk;
  end

  rtc_tick_prescaler u_rtc_tick_prescaler (
    .sys_clk_i(sys_clk), .rtc_clk_i(rtc_clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tick_o(tick), .flag_o(flag), .irq_o(irq)
  );

  function automatic int period_of(int n);
    return (n == 0) ? 128 : 64 * (n + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge sys_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge sys_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    int n = tick_cnt;
    while (tick_cnt == n) @(negedge rtc_clk);
  endtask

  // reference: expected tick every period, compared each RTC cycle once locked
  always @(negedge rtc_clk) begin
    rtc_cyc++;
    if (tick && !tick_prev) begin
      tick_cnt++;
      last_tick_cyc = rtc_cyc;
    end
    tick_prev = tick;
    if (!lock_req) locked = 0;
    else if (locked) begin
      remaining--;
      check(tick == (remaining == 0), "R1/R2/R5/R11 tick", int'(tick), int'(remaining == 0));
      if (remaining == 0) remaining = period_of(model_pend);
    end else if (tick) begin
      locked = 1;
      remaining = period_of(model_pend);
    end
  end

  task automatic service_tick();
    wait_tick();
    repeat (6) @(negedge sys_clk);
    check(flag == 1'b1, "R8 flag set", int'(flag), 1);
    check(irq == irq_exp, "R10 irq", int'(irq), int'(irq_exp));
    wr(2'd1, 16'h0001);
    check(flag == 1'b0, "R9 w1c clear", int'(flag), 0);
    check(irq == 1'b0, "R10 irq after clear", int'(irq), 0);
    repeat (10) @(negedge sys_clk);
    check(flag == 1'b0, "R8 single set per tick", int'(flag), 0);
  endtask

  initial begin
    repeat (195000) @(posedge sys_clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int start, lat, n;
    repeat (5) @(negedge sys_clk);
    check(tick == 1'b0 && flag == 1'b0 && irq == 1'b0, "R6 reset outputs",
          int'({tick, flag, irq}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge sys_clk);
    check(flag == 1'b0, "R6 flag after reset", int'(flag), 0);

    // default reload: 1-second period at 32768 Hz
    start = rtc_cyc;
    wr(2'd0, 16'h0001);
    wait_tick();
    lat = last_tick_cyc - start;
    check(lat >= 32768 && lat <= 32773, "R6 default period", lat, 32768);
    repeat (6) @(negedge sys_clk);
    check(flag == 1'b1, "R8 flag after first tick", int'(flag), 1);
    check(irq == 1'b0, "R10 irq masked", int'(irq), 0);
    wr(2'd1, 16'h0000);
    check(flag == 1'b1, "R9 zero write keeps flag", int'(flag), 1);
    wr(2'd1, 16'h0001);
    check(flag == 1'b0, "R9 clear", int'(flag), 0);

    // disabled: no ticks
    wr(2'd0, 16'h0000);
    repeat (4) @(negedge rtc_clk);
    n = tick_cnt;
    repeat (300) @(negedge rtc_clk);
    check(tick_cnt == n, "R7 no tick while disabled", tick_cnt - n, 0);
    check(flag == 1'b0, "R7 no flag while disabled", int'(flag), 0);

    // reload 3 committed while off; first period after enable is full
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0003);
    model_pend = 3;
    repeat (8) @(negedge rtc_clk);
    irq_exp = 1;
    lock_req = 1;
    start = rtc_cyc;
    wr(2'd0, 16'h0003);
    wait_tick();
    lat = last_tick_cyc - start;
    check(lat >= 256 && lat <= 261, "R7 full first period", lat, 256);
    repeat (6) @(negedge sys_clk);
    wr(2'd1, 16'h0001);
    service_tick();

    // zero reload: current period finishes (R5), then divide-by-2 (R2)
    wr(2'd3, 16'h0000);
    model_pend = 0;
    repeat (3) service_tick();

    // R1 with N=5
    wr(2'd3, 16'h0005);
    model_pend = 5;
    repeat (3) service_tick();

    // R4: high half alone changes nothing
    wr(2'd2, 16'h0001);
    repeat (2) service_tick();

    // R3: commit 0x10000; after current period no tick for a long stretch
    wr(2'd3, 16'h0000);
    model_pend = 32'h10000;
    service_tick();
    n = tick_cnt;
    repeat (1000) @(negedge rtc_clk);
    check(tick_cnt == n, "R3 high bits decoded", tick_cnt - n, 0);

    lock_req = 0;
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0001);
    model_pend = 1;
    repeat (8) @(negedge rtc_clk);
    lock_req = 1;
    wr(2'd0, 16'h0003);
    wait_tick();
    repeat (6) @(negedge sys_clk);
    wr(2'd1, 16'h0001);
    repeat (2) service_tick();

    summary();
  end
endmodule